// File: doc/BRIEF.md
# Exception Readiness Evaluator

This block answers one question for an exception controller: if the given exception were raised now, would it be allowed to pre-empt what is currently running? An exception counts as ready when its enable bit is set and its group priority is strictly below the current execution priority. The hard-fault exception is the one exception handled differently. Lower numbers are more urgent, and priorities are signed, so the fixed negative levels of the most urgent exceptions compare correctly against the running level.

The caller presents an exception number, a secure-bank select and the current execution priority for one cycle. The block looks the exception up in one of two vector tables, secure or non-secure, both supplied as flat input buses. It masks the raw priority with the grouping setting of the selected security state and compares the result with the running level. The answer is registered and appears one cycle later with a valid strobe. A request that breaks the numbering or banking rules returns an error flag, and its ready bit is held low.

The running priority itself, pending and active tracking, and vector fetch are computed elsewhere and are not part of this block.

Top module: `exc_ready_eval`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high and low otherwise; whenever `rsp_valid` is low, `rsp_ready` and `rsp_error` are also low.
- R2: For a legal request that is not the hard fault, `rsp_ready` is 1 exactly when the selected enable bit is 1 and the grouped priority, taken as a non-negative value, is strictly less than `run_prio`, read as a two's-complement number.
- R3: The grouped priority is the raw 8-bit priority with its lowest (G+1) bits cleared. G is `grp_s` when `req_secure` is 1 and `grp_ns` otherwise.
- R4: The enable bit is `en_s[n]` or `en_ns[n]`, and the raw priority is `prio_s[n*8 +: 8]` or `prio_ns[n*8 +: 8]`, where n is the exception number. The secure table is used when `req_secure` is 1 and n is a banked exception; otherwise the non-secure table is used.
- R5: For exception number 3 (hard fault), `rsp_ready` is 1 exactly when `run_prio` is 0 or more. The enable bits, the table priorities and the grouping settings have no effect on this result.
- R6: An exception number of 1 or less, or of 32 (the configured count) or more, gives `rsp_error` = 1 and `rsp_ready` = 0.
- R7: The banked exception numbers are 3, 4, 6, 11, 14 and 15. A request with `req_secure` = 1 for any other in-range number gives `rsp_error` = 1 and `rsp_ready` = 0.
- R8: When `run_prio` is negative (for example -1, -2 or -3), no exception is reported ready. When `run_prio` is 256, the level meaning that nothing is running, every enabled legal exception is reported ready.
- R9: While reset is asserted, `rsp_valid`, `rsp_ready` and `rsp_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_exc | input | 6 | Exception number |
| req_secure | input | 1 | Select the secure bank of a banked exception |
| run_prio | input | 10 | Current execution priority, two's complement |
| grp_s | input | 3 | Priority grouping setting, secure state |
| grp_ns | input | 3 | Priority grouping setting, non-secure state |
| en_s | input | 32 | Secure table enable bits, bit n for exception n |
| en_ns | input | 32 | Non-secure table enable bits |
| prio_s | input | 256 | Secure table raw priorities, 8 bits per exception |
| prio_ns | input | 256 | Non-secure table raw priorities |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ready | output | 1 | Exception would pre-empt the running level |
| rsp_error | output | 1 | Request broke the range or bank rules |

## Verification
The case that is hardest to reach from the ports is a request whose outcome depends on the bank and the grouping at once. The two tables must then disagree, and the grouping mask must move the priority across the running level. Random tables seldom set up that combination. The bench therefore fills the two tables from different arithmetic patterns, so their enables and priorities differ on most entries. It sweeps every exception number with both bank selects against several grouping settings and running levels, including the negative levels and the nothing-running level. Directed requests then put a priority just above the running level, where only the grouping decides the result.

// File: rtl/exc_ready_pkg.sv
package exc_ready_pkg;

    typedef struct packed {
        logic valid;
        logic ready;
        logic error;
    } rsp_t;

endpackage

// File: rtl/exc_table_read.sv
module exc_table_read #(
    parameter int NUM_EXC   = 32,
    parameter int PRIO_BITS = 8,
    parameter int SEL_W     = 5
) (
    input  logic [NUM_EXC-1:0]           en_tab,
    input  logic [NUM_EXC*PRIO_BITS-1:0] prio_tab,
    input  logic [SEL_W-1:0]             sel,
    output logic                         en_o,
    output logic [PRIO_BITS-1:0]         prio_o
);

    always_comb begin
        en_o   = 1'b0;
        prio_o = '0;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (sel == SEL_W'(i)) begin
                en_o   = en_tab[i];
                prio_o = prio_tab[i*PRIO_BITS +: PRIO_BITS];
            end
        end
    end

endmodule

// File: rtl/exc_prio_group.sv
module exc_prio_group #(
    parameter int PRIO_BITS = 8,
    parameter int GRP_W     = 3,
    parameter int SPRIO_W   = 10
) (
    input  logic [PRIO_BITS-1:0]      raw_prio,
    input  logic [GRP_W-1:0]          grp,
    output logic signed [SPRIO_W-1:0] group_prio
);

    logic [PRIO_BITS-1:0] masked;

    // A bit survives only if it sits above the sub-priority field of grp+1 bits.
    always_comb begin
        for (int b = 0; b < PRIO_BITS; b++) begin
            masked[b] = raw_prio[b] && (b > int'(grp));
        end
        group_prio = $signed({{(SPRIO_W-PRIO_BITS){1'b0}}, masked});
    end

endmodule

// File: rtl/exc_ready_cmp.sv
module exc_ready_cmp #(
    parameter int SPRIO_W = 10
) (
    input  logic                      is_hard,
    input  logic                      en,
    input  logic signed [SPRIO_W-1:0] group_prio,
    input  logic signed [SPRIO_W-1:0] run_prio,
    output logic                      ready_o
);

    localparam logic signed [SPRIO_W-1:0] HARD_LEVEL = -1;

    always_comb begin
        if (is_hard) begin
            ready_o = run_prio > HARD_LEVEL;
        end else begin
            ready_o = en && (group_prio < run_prio);
        end
    end

endmodule

// File: rtl/exc_ready_eval.sv
module exc_ready_eval #(
    parameter int                 NUM_EXC     = 32,
    parameter int                 PRIO_BITS   = 8,
    parameter int                 GRP_W       = 3,
    parameter int                 RESET_EXC   = 1,
    parameter int                 HARD_EXC    = 3,
    parameter logic [NUM_EXC-1:0] BANKED_MASK = NUM_EXC'(32'h0000_C858),
    localparam int                SEL_W       = $clog2(NUM_EXC),
    localparam int                IDX_W       = SEL_W + 1,
    localparam int                SPRIO_W     = PRIO_BITS + 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [IDX_W-1:0]             req_exc,
    input  logic                         req_secure,
    input  logic [SPRIO_W-1:0]           run_prio,
    input  logic [GRP_W-1:0]             grp_s,
    input  logic [GRP_W-1:0]             grp_ns,
    input  logic [NUM_EXC-1:0]           en_s,
    input  logic [NUM_EXC-1:0]           en_ns,
    input  logic [NUM_EXC*PRIO_BITS-1:0] prio_s,
    input  logic [NUM_EXC*PRIO_BITS-1:0] prio_ns,
    output logic                         rsp_valid,
    output logic                         rsp_ready,
    output logic                         rsp_error
);

    import exc_ready_pkg::*;

    rsp_t st_d, st_q;

    logic [SEL_W-1:0]             sel;
    logic                         in_range;
    logic                         banked;
    logic                         use_sec;
    logic                         req_bad;
    logic [GRP_W-1:0]             grp_sel;
    logic [NUM_EXC-1:0]           en_all   [2];
    logic [NUM_EXC*PRIO_BITS-1:0] prio_all [2];
    logic [1:0]                   bank_en;
    logic [PRIO_BITS-1:0]         bank_prio [2];
    logic                         en_pick;
    logic [PRIO_BITS-1:0]         prio_pick;
    logic signed [SPRIO_W-1:0]    group_prio;
    logic                         ready_raw;

    // Bank 0 is the non-secure table, bank 1 the secure one.
    assign en_all[0]   = en_ns;
    assign en_all[1]   = en_s;
    assign prio_all[0] = prio_ns;
    assign prio_all[1] = prio_s;

    assign sel      = req_exc[SEL_W-1:0];
    assign in_range = (req_exc > IDX_W'(RESET_EXC)) && (req_exc < IDX_W'(NUM_EXC));
    assign banked   = in_range && BANKED_MASK[sel];
    assign use_sec  = req_secure && banked;
    assign req_bad  = !in_range || (req_secure && !banked);
    assign grp_sel  = req_secure ? grp_s : grp_ns;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        exc_table_read #(
            .NUM_EXC   (NUM_EXC),
            .PRIO_BITS (PRIO_BITS),
            .SEL_W     (SEL_W)
        ) u_read (
            .en_tab   (en_all[b]),
            .prio_tab (prio_all[b]),
            .sel      (sel),
            .en_o     (bank_en[b]),
            .prio_o   (bank_prio[b])
        );
    end

    assign en_pick   = use_sec ? bank_en[1]   : bank_en[0];
    assign prio_pick = use_sec ? bank_prio[1] : bank_prio[0];

    exc_prio_group #(
        .PRIO_BITS (PRIO_BITS),
        .GRP_W     (GRP_W),
        .SPRIO_W   (SPRIO_W)
    ) u_group (
        .raw_prio   (prio_pick),
        .grp        (grp_sel),
        .group_prio (group_prio)
    );

    exc_ready_cmp #(
        .SPRIO_W (SPRIO_W)
    ) u_cmp (
        .is_hard    (req_exc == IDX_W'(HARD_EXC)),
        .en         (en_pick),
        .group_prio (group_prio),
        .run_prio   ($signed(run_prio)),
        .ready_o    (ready_raw)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = req_valid;
        st_d.error = req_valid && req_bad;
        st_d.ready = req_valid && !req_bad && ready_raw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_ready = st_q.ready;
    assign rsp_error = st_q.error;

endmodule

module exc_ready_eval_chk #(
    parameter int                 NUM_EXC     = 32,
    parameter int                 PRIO_BITS   = 8,
    parameter int                 GRP_W       = 3,
    parameter int                 RESET_EXC   = 1,
    parameter int                 HARD_EXC    = 3,
    parameter logic [NUM_EXC-1:0] BANKED_MASK = NUM_EXC'(32'h0000_C858),
    localparam int                SEL_W       = $clog2(NUM_EXC),
    localparam int                IDX_W       = SEL_W + 1,
    localparam int                SPRIO_W     = PRIO_BITS + 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic [IDX_W-1:0]             req_exc,
    input logic                         req_secure,
    input logic [SPRIO_W-1:0]           run_prio,
    input logic [GRP_W-1:0]             grp_s,
    input logic [GRP_W-1:0]             grp_ns,
    input logic [NUM_EXC-1:0]           en_s,
    input logic [NUM_EXC-1:0]           en_ns,
    input logic [NUM_EXC*PRIO_BITS-1:0] prio_s,
    input logic [NUM_EXC*PRIO_BITS-1:0] prio_ns,
    input logic                         rsp_valid,
    input logic                         rsp_ready,
    input logic                         rsp_error
);

    logic             c_inr;
    logic [SEL_W-1:0] c_sel;
    logic             c_en;

    assign c_sel = req_exc[SEL_W-1:0];
    assign c_inr = (int'(req_exc) > RESET_EXC) && (int'(req_exc) < NUM_EXC);
    assign c_en  = (req_secure && BANKED_MASK[c_sel]) ? en_s[c_sel] : en_ns[c_sel];

    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_ready && !rsp_error));

    assert_disabled_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_inr && (int'(req_exc) != HARD_EXC) && !c_en) |=> !rsp_ready);

    assert_hard_fault_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (int'(req_exc) == HARD_EXC)) |=> (rsp_ready == !$past(run_prio[SPRIO_W-1])));

    assert_range_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !c_inr) |=> (rsp_error && !rsp_ready));

    assert_bank_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && c_inr && req_secure && !BANKED_MASK[c_sel]) |=> (rsp_error && !rsp_ready));

    assert_negative_run_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && run_prio[SPRIO_W-1]) |=> !rsp_ready);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R9: assert (!rsp_valid && !rsp_ready && !rsp_error);
        end
    end

endmodule

bind exc_ready_eval exc_ready_eval_chk #(
    .NUM_EXC     (NUM_EXC),
    .PRIO_BITS   (PRIO_BITS),
    .GRP_W       (GRP_W),
    .RESET_EXC   (RESET_EXC),
    .HARD_EXC    (HARD_EXC),
    .BANKED_MASK (BANKED_MASK)
) u_chk (.*);

// File: tb/exc_ready_eval_bench.sv
`timescale 1ns/1ps
module exc_ready_eval_bench;

    localparam int N  = 32;
    localparam int PB = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [5:0]        req_exc = '0;
    logic              req_secure = 1'b0;
    logic [9:0]        run_prio = '0;
    logic [2:0]        grp_s = '0;
    logic [2:0]        grp_ns = '0;
    logic [N-1:0]      en_s = '0;
    logic [N-1:0]      en_ns = '0;
    logic [N*PB-1:0]   prio_s = '0;
    logic [N*PB-1:0]   prio_ns = '0;
    logic              rsp_valid, rsp_ready, rsp_error;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    exc_ready_eval u_exc_ready_eval (
        .clk, .rst_n, .req_valid, .req_exc, .req_secure, .run_prio,
        .grp_s, .grp_ns, .en_s, .en_ns, .prio_s, .prio_ns,
        .rsp_valid, .rsp_ready, .rsp_error
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit is_banked(input int n);
        return n == 3 || n == 4 || n == 6 || n == 11 || n == 14 || n == 15;
    endfunction

    // Expected response built from the requirement text.
    task automatic expect_rsp(input int n, input bit sec, input int run,
                              output bit er, output bit rd, output string tag);
        int  p, g, gp;
        bit  en;
        er = (n <= 1) || (n >= N) || (sec && !is_banked(n));
        rd = 0;
        if (er) begin
            tag = ((n <= 1) || (n >= N)) ? "R6" : "R7";
        end else if (n == 3) begin
            tag = "R5";
            rd  = run >= 0;
        end else begin
            en  = sec ? en_s[n] : en_ns[n];
            p   = sec ? int'(prio_s[n*PB +: PB]) : int'(prio_ns[n*PB +: PB]);
            g   = sec ? int'(grp_s) : int'(grp_ns);
            gp  = (p >> (g + 1)) << (g + 1);
            rd  = en && (gp < run);
            tag = (run < 0 || run == 256) ? "R8" : (sec ? "R4" : "R2");
        end
    endtask

    task automatic request(input int n, input bit sec, input int run, input string force_tag);
        bit    er, rd;
        string tag;
        @(negedge clk);
        req_valid  = 1'b1;
        req_exc    = 6'(n);
        req_secure = sec;
        run_prio   = 10'(run);
        expect_rsp(n, sec, run, er, rd, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1", "rsp_valid", int'(rsp_valid), 1);
        check(tag, $sformatf("ready exc %0d sec %0d run %0d", n, sec, run), int'(rsp_ready), int'(rd));
        check(tag, $sformatf("error exc %0d sec %0d", n, sec), int'(rsp_error), int'(er));
    endtask

    task automatic fill_tables(input int k);
        for (int i = 0; i < N; i++) begin
            en_ns[i] = ((i * 7 + k) % 3) != 0;
            en_s[i]  = ((i * 5 + k) % 4) != 1;
            prio_ns[i*PB +: PB] = PB'((i * 37 + k * 11) % 256);
            prio_s[i*PB +: PB]  = PB'((i * 53 + k * 29 + 100) % 256);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int runs [8] = '{-3, -1, 0, 1, 64, 128, 255, 256};
        int grps [3] = '{0, 3, 7};
        // R9: outputs quiet during reset, even with a request pending
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "rsp_valid in reset", int'(rsp_valid), 0);
        check("R9", "rsp_ready in reset", int'(rsp_ready), 0);
        check("R9", "rsp_error in reset", int'(rsp_error), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle rsp_valid", int'(rsp_valid), 0);

        // R1: no response in the cycle after an idle cycle
        request(5, 0, 256, "");
        @(negedge clk);
        check("R1", "rsp_valid after idle", int'(rsp_valid), 0);
        check("R1", "rsp_ready after idle", int'(rsp_ready), 0);

        // R3: grouping alone moves the answer across the running level
        fill_tables(0);
        en_ns[5] = 1'b1;
        prio_ns[5*PB +: PB] = 8'h13;
        grp_ns = 3'd0;
        request(5, 0, 'h12, "R3");
        grp_ns = 3'd1;
        request(5, 0, 'h12, "R3");
        grp_s = 3'd7;
        request(5, 0, 'h12, "R3");

        // R4: secure and non-secure entries disagree on a banked exception
        en_s[4] = 1'b1;  prio_s[4*PB +: PB] = 8'h10;
        en_ns[4] = 1'b0; prio_ns[4*PB +: PB] = 8'h10;
        grp_s = 3'd0; grp_ns = 3'd0;
        request(4, 1, 'h40, "R4");
        request(4, 0, 'h40, "R4");

        // R5: hard fault disabled in both banks with the lowest priority
        en_s[3] = 1'b0; en_ns[3] = 1'b0;
        prio_s[3*PB +: PB] = 8'hFF; prio_ns[3*PB +: PB] = 8'hFF;
        request(3, 0, 0, "R5");
        request(3, 1, -1, "R5");

        // Sweep: all numbers, both banks, grouping settings, running levels
        for (int k = 0; k < 4; k++) begin
            fill_tables(k);
            for (int gi = 0; gi < 3; gi++) begin
                grp_ns = 3'(grps[gi]);
                grp_s  = 3'(grps[(gi + k) % 3]);
                for (int ri = 0; ri < 8; ri++) begin
                    for (int n = 0; n < 64; n++) begin
                        for (int s = 0; s < 2; s++) begin
                            request(n, s[0], runs[ri], "");
                        end
                    end
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule